// File: doc/BRIEF.md
# E1 Timeslot Idle-Code and Loopback Inserter

This block sits in the transmit path of an E1 framer, between the serial backplane input and the serial line output. It follows the 32 eight-bit timeslots of each frame from a bit clock and a frame sync pulse. For every timeslot it selects one of four sources: the backplane bit, a shared idle code, the receive-side bit (per-channel loopback), or a code byte owned by that channel alone.

One 32-bit channel mask has two uses, chosen by a mode bit. With the mode bit at 0, a set mask bit puts the shared idle code into that channel. With the mode bit at 1, a set mask bit loops the receive-side data back into that channel. In loopback the receive stream is assumed to be bit-aligned with the transmit stream, so the receive bit for the current position is used directly. A second 32-bit mask enables per-channel codes, with one code register for each channel.

A byte-wide register bus writes and reads back all of the configuration. Its write strobe acts on the rising clock edge, and reads are combinational. Each decision is made on the first bit of a timeslot and held for the other seven bits, so a channel never carries a mix of old and new settings.

Top module: `e1_ts_inserter`

## Requirements
- R1: One bit is handled per clock. Eight bits form a timeslot, and timeslots CH1 to CH32 form a 256-bit frame. Without a sync pulse the position wraps from CH32 bit 7 to CH1 bit 0.
- R2: The register map is fixed. The loop/idle mask sits at 0x26 to 0x29, where bit i of register 0x26+k is channel 8k+i+1. The idle code is at 0x2A. The mode bit is bit 0 of 0x2B, and the other bits of 0x2B read 0. The per-channel code enable mask sits at 0x2C to 0x2F with the same layout. The code for channel n is at 0x30+n-1. Every register reads back what was written. Other addresses read 0 and ignore writes.
- R3: After reset every register reads 0 and the output equals the backplane input.
- R4: A channel with both mask bits clear carries the backplane bit unchanged.
- R5: With the mode bit at 0, a channel with its loop/idle mask bit set and its code enable bit clear carries the idle code, bit 7 in the first bit of the timeslot and bit 0 in the last.
- R6: With the mode bit at 1, a channel with its loop/idle mask bit set and its code enable bit clear carries the receive input bit of the same cycle.
- R7: A channel with its code enable bit set carries its own code, most significant bit first. This takes priority over R5 and R6.
- R8: The source and code byte of a timeslot are taken from the register contents seen on its first bit. Writes that land later in the slot take effect from the next timeslot.
- R9: A frame sync pulse makes its cycle CH1 bit 0, whatever position the counter held, and counting continues from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync: this cycle is CH1 bit 0 |
| bp_data | input | 1 | Backplane serial data |
| rx_data | input | 1 | Receive-side serial data, aligned with transmit |
| tx_data | output | 1 | Serial output toward the line |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Register read data for bus_addr |

## Verification
The bench builds the block with its default parameters: 32 channels and the standard address bases. With these values every register, the loopback mode and the 256-bit frame wrap are all reached. Random register writes land at every bit offset within a slot, which exercises both the priority between the two methods and the rule that a decision is fixed on the first bit. Frames run both with and without sync pulses, and one sync pulse arrives in the middle of a slot to test resynchronisation.

// File: rtl/e1_ts_inserter.sv
module e1_ts_inserter #(
  parameter int          NCH        = 32,
  parameter logic [7:0]  IMASK_BASE = 8'h26,
  parameter logic [7:0]  IDLE_ADDR  = 8'h2A,
  parameter logic [7:0]  CTRL_ADDR  = 8'h2B,
  parameter logic [7:0]  PMASK_BASE = 8'h2C,
  parameter logic [7:0]  CODE_BASE  = 8'h30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fsync,
  input  logic       bp_data,
  input  logic       rx_data,
  output logic       tx_data,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_we,
  output logic [7:0] bus_rdata
);
  localparam int NB  = NCH / 8;
  localparam int TSW = $clog2(NCH);
  localparam logic [1:0] SRC_BP = 2'd0, SRC_IDLE = 2'd1, SRC_RX = 2'd2, SRC_CODE = 2'd3;

  logic [TSW-1:0] ts_q, cur_ts;
  logic [2:0]     bit_q, cur_bit;
  logic [NCH-1:0] imask, pmask;
  logic [7:0]     idle_code;
  logic           loop_mode;
  logic [7:0]     code [NCH];
  logic [1:0]     new_src, snap_src, use_src;
  logic [7:0]     new_code, snap_code, use_code;

  assign cur_ts  = fsync ? '0 : ts_q;
  assign cur_bit = fsync ? '0 : bit_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {ts_q, bit_q} <= '0;
    else        {ts_q, bit_q} <= {cur_ts, cur_bit} + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      imask <= '0; pmask <= '0; idle_code <= '0; loop_mode <= 1'b0;
      for (int n = 0; n < NCH; n++) code[n] <= '0;
    end else if (bus_we) begin
      for (int k = 0; k < NB; k++) begin
        if (bus_addr == IMASK_BASE + 8'(k)) imask[8*k +: 8] <= bus_wdata;
        if (bus_addr == PMASK_BASE + 8'(k)) pmask[8*k +: 8] <= bus_wdata;
      end
      if (bus_addr == IDLE_ADDR) idle_code <= bus_wdata;
      if (bus_addr == CTRL_ADDR) loop_mode <= bus_wdata[0];
      for (int n = 0; n < NCH; n++)
        if (bus_addr == CODE_BASE + 8'(n)) code[n] <= bus_wdata;
    end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NB; k++) begin
      if (bus_addr == IMASK_BASE + 8'(k)) bus_rdata = imask[8*k +: 8];
      if (bus_addr == PMASK_BASE + 8'(k)) bus_rdata = pmask[8*k +: 8];
    end
    if (bus_addr == IDLE_ADDR) bus_rdata = idle_code;
    if (bus_addr == CTRL_ADDR) bus_rdata = {7'd0, loop_mode};
    for (int n = 0; n < NCH; n++)
      if (bus_addr == CODE_BASE + 8'(n)) bus_rdata = code[n];
  end

  always_comb begin
    new_src  = SRC_BP;
    new_code = '0;
    if (pmask[cur_ts]) begin
      new_src  = SRC_CODE;
      new_code = code[cur_ts];
    end else if (imask[cur_ts]) begin
      new_src  = loop_mode ? SRC_RX : SRC_IDLE;
      new_code = idle_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      snap_src <= SRC_BP; snap_code <= '0;
    end else if (cur_bit == 3'd0) begin
      snap_src <= new_src; snap_code <= new_code;
    end

  assign use_src  = (cur_bit == 3'd0) ? new_src  : snap_src;
  assign use_code = (cur_bit == 3'd0) ? new_code : snap_code;

  always_comb
    case (use_src)
      SRC_BP:  tx_data = bp_data;
      SRC_RX:  tx_data = rx_data;
      default: tx_data = use_code[~cur_bit];
    endcase

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && bit_q == 3'd7) |=> (bit_q == 3'd0 && ts_q == $past(ts_q) + 1'b1)); // R1
  AST_FSYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (ts_q == '0 && bit_q == 3'd1)); // R9
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_bit != 3'd0) |-> (use_src == $past(use_src) && use_code == $past(use_code))); // R8
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_bit == 3'd0 && !pmask[cur_ts] && !imask[cur_ts]) |-> tx_data == bp_data); // R4
  AST_LOOP_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_bit == 3'd0 && loop_mode && imask[cur_ts] && !pmask[cur_ts]) |-> tx_data == rx_data); // R6
  AST_CODE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_bit == 3'd0 && pmask[cur_ts]) |-> tx_data == code[cur_ts][7]); // R7
endmodule

// File: tb/sim_e1_ts_inserter.sv
module sim_e1_ts_inserter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, bp = 1'b0, rx = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic tx;
  logic [7:0] rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_ts_inserter u0 (.clk(clk), .rst_n(rst_n), .fsync(fsync), .bp_data(bp), .rx_data(rx),
                     .tx_data(tx), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
                     .bus_rdata(rdata));

  int checks = 0, errors = 0;
  logic [31:0] m_imask = '0, m_pmask = '0;
  logic [7:0]  m_idle = '0;
  logic        m_mode = 1'b0;
  logic [7:0]  m_code [32];
  int s_src = 0;
  logic [7:0] s_code = '0;
  int bts = 0, bbit = 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int src_of(input int ts);
    if (m_pmask[ts]) return 3;
    if (m_imask[ts]) return m_mode ? 2 : 1;
    return 0;
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a >= 8'h26 && a <= 8'h29) return m_imask[8*(a-8'h26) +: 8];
    if (a == 8'h2A) return m_idle;
    if (a == 8'h2B) return {7'd0, m_mode};
    if (a >= 8'h2C && a <= 8'h2F) return m_pmask[8*(a-8'h2C) +: 8];
    if (a >= 8'h30 && a <= 8'h4F) return m_code[a-8'h30];
    return 8'h00;
  endfunction

  task automatic mwrite(input logic [7:0] a, input logic [7:0] d);
    if (a >= 8'h26 && a <= 8'h29) m_imask[8*(a-8'h26) +: 8] = d;
    else if (a == 8'h2A) m_idle = d;
    else if (a == 8'h2B) m_mode = d[0];
    else if (a >= 8'h2C && a <= 8'h2F) m_pmask[8*(a-8'h2C) +: 8] = d;
    else if (a >= 8'h30 && a <= 8'h4F) m_code[a-8'h30] = d;
  endtask

  task automatic step(input logic f, input logic b, input logic r, input logic w,
                      input logic [7:0] a, input logic [7:0] d, input string rtag);
    int ts, bi, idx;
    logic e;
    string tg;
    @(negedge clk);
    fsync = f; bp = b; rx = r; we = w; addr = a; wdata = d;
    #1;
    ts = f ? 0 : bts;
    bi = f ? 0 : bbit;
    if (bi == 0) begin
      s_src  = src_of(ts);
      s_code = (s_src == 3) ? m_code[ts] : m_idle;
    end
    case (s_src)
      0: e = b;
      2: e = r;
      default: e = s_code[7-bi];
    endcase
    if (rtag != "") tg = rtag;
    else if (f && (bts != 0 || bbit != 0)) tg = "R9";
    else if (bi != 0 && src_of(ts) != s_src) tg = "R8";
    else if (s_src == 0) tg = "R4";
    else if (s_src == 1) tg = "R5";
    else if (s_src == 2) tg = "R6";
    else tg = "R7";
    chk(tx === e, {tg, " tx"}, int'(tx), int'(e));
    chk(rdata === exp_read(a), (rtag != "") ? {rtag, " rdata"} : "R2 rdata",
        int'(rdata), int'(exp_read(a)));
    @(posedge clk);
    if (w) mwrite(a, d);
    idx  = ts * 8 + bi + 1;
    bts  = (idx / 8) % 32;
    bbit = idx % 8;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [7:0] ra;
    seed = $urandom(32'd20240607);
    for (int n = 0; n < 32; n++) m_code[n] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int a = 8'h24; a <= 8'h51; a++)
      step(1'b0, 1'($urandom), 1'($urandom), 1'b0, 8'(a), 8'h00, "R3");

    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h26, 8'h03, "");
    step(1'b0, 1'b1, 1'b0, 1'b1, 8'h2A, 8'hA5, "");
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h31, 8'h3C, "");
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h2C, 8'h02, "");
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h55, 8'hFF, "");
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 8'h00, "R2");
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h26, 8'h00, "R2");
    for (int i = 0; i < 512; i++)
      step(i == 250, 1'($urandom), 1'($urandom), 1'b0, 8'h2C, 8'h00, "");
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h2B, 8'hFF, "");
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h2B, 8'h00, "R2");
    for (int i = 0; i < 512; i++)
      step(1'b0, 1'($urandom), 1'($urandom), 1'b0, 8'h2B, 8'h00, "");

    for (int i = 0; i < 40000; i++) begin
      logic f, w;
      f = (bts == 0 && bbit == 0 && $urandom_range(1, 0) == 1) ||
          (i % 3001 == 1500);
      w = ($urandom_range(15, 0) == 0);
      if ($urandom_range(9, 0) == 0) ra = 8'($urandom);
      else ra = 8'h26 + 8'($urandom_range(41, 0));
      step(f, 1'($urandom), 1'($urandom), w, ra, 8'($urandom), "");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule